// File: doc/BRIEF.md
# Programmable Interval Counter Channel

A single 16-bit down-counter channel for an interval timer. The counter advances only on cycles where the tick enable input is high, so one fast system clock can drive a slower counting rate. A gate input either pauses counting or restarts it, depending on the selected mode. An output pin produces the level the mode calls for: a terminal-count flag, a one-tick pulse, or a square wave.

Software configures the channel through a single load transfer. Each load carries a 16-bit initial value, a 3-bit mode and a decimal-select flag. The load interface uses a valid/ready handshake. A load is accepted on any clock edge where both `ld_valid` and `ld_ready` are high. `ld_ready` is always high, so the channel never applies back-pressure and a valid load is never stalled. The decimal-select flag is stored and reported but does not change counting, which is always binary. The live count and the output level are always visible on the ports.

Top module: `pic_channel`

## Requirements
- R1: After reset, `count_o` is 0, `out_o` is 0, `mode_o` is 0 and `ld_ready` is 1. Until the first load is accepted, the count and the output do not change, whatever the tick and gate inputs do.
- R2: A load is accepted when `ld_valid` and `ld_ready` are both high at a clock edge. From the next cycle, `mode_o` and `bcd_o` show the loaded mode and flag, and `count_o` holds the loaded value (for the exception, see R8). A load takes priority over any gate restart or tick in the same cycle.
- R3: A loaded initial value of 0 acts as a period of 65536 ticks. In mode 0, `out_o` rises exactly 65536 ticks after the load.
- R4: In modes 0, 1, 4 and 5, each tick lowers the count by one and wraps from 0 to 0xFFFF. In mode 0, `out_o` is low after a load, goes high on the tick that takes the count from 1 to 0, and stays high until the next load. In modes 1, 4 and 5, `out_o` is high after a load.
- R5: In modes 0 and 4, while `gate` is low, ticks do not change the count. A rising gate edge in these modes never reloads the count.
- R6: In modes 1, 2, 3 and 5 (and their aliases 6 and 7), a rising gate edge reloads the count from the initial value on the next cycle and sets `out_o` high. A rising edge is a cycle where `gate` is 1 and `gate` was 0 at the previous clock edge. Gate level does not pause counting in these modes.
- R7: In mode 2, for an initial value N of 2 or more, the count runs N, N-1, …, 1. `out_o` is low only while the count is 1, which lasts one tick. The next tick reloads N and raises `out_o`, so the period is N ticks.
- R8: In mode 3, `out_o` is high after a load and each tick lowers the count by two. On the tick where the count is 2, `out_o` toggles and the count reloads for the next half period. For an even N, the reload value is N and each half lasts N/2 ticks. For an odd N, the high half starts at N+1 and lasts (N+1)/2 ticks, and the low half starts at N-1 and lasts (N-1)/2 ticks. N must be at least 2; N = 0 gives two halves of 32768 ticks.
- R9: Mode values 6 and 7 behave exactly like modes 2 and 3. `mode_o` still reports the value that was written.
- R10: In a cycle where `tick_en` is low, the count and the output do not change, except through a load or a gate restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counting enable; one tick per high cycle |
| gate | input | 1 | Gate level, sampled on the system clock |
| ld_valid | input | 1 | Load transfer valid |
| ld_ready | output | 1 | Load transfer ready (always high) |
| ld_value | input | 16 | Initial count value |
| ld_mode | input | 3 | Counting mode, 0 to 7 |
| ld_bcd | input | 1 | Decimal-select flag (stored only) |
| count_o | output | 16 | Live count |
| out_o | output | 1 | Output pin level |
| mode_o | output | 3 | Stored mode |
| bcd_o | output | 1 | Stored decimal-select flag |

## Verification
The embedded properties check several behaviours on every cycle:
- the count holds while the gate pauses modes 0 and 4, or while the tick enable is low;
- the mode-3 count stays even;
- in mode 2, the output is low only when the count is 1;
- in mode 0, the output rises only when the count reaches zero;
- a gate edge in a retriggerable mode reloads the initial value.

Other behaviours span many cycles, so only the bench scenarios can show them: the exact mode-2 period, the unequal high and low halves for an odd square-wave value, the 65536-tick period after loading zero, and the aliasing of modes 6 and 7.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam logic [2:0] MODE_TERM    = 3'd0;
  localparam logic [2:0] MODE_ONESHOT = 3'd1;
  localparam logic [2:0] MODE_RATE    = 3'd2;
  localparam logic [2:0] MODE_SQUARE  = 3'd3;
  localparam logic [2:0] MODE_SWSTB   = 3'd4;
  localparam logic [2:0] MODE_HWSTB   = 3'd5;

  // modes 6 and 7 fold onto 2 and 3
  function automatic logic [2:0] eff_mode(input logic [2:0] m);
    return m[1] ? {1'b0, m[1:0]} : m;
  endfunction

  // gate level pauses counting
  function automatic logic gate_pauses(input logic [2:0] em);
    return (em == MODE_TERM) || (em == MODE_SWSTB);
  endfunction

  // gate rising edge restarts counting
  function automatic logic gate_retrigs(input logic [2:0] em);
    return (em == MODE_ONESHOT) || (em == MODE_RATE) ||
           (em == MODE_SQUARE) || (em == MODE_HWSTB);
  endfunction
endpackage

// File: rtl/pic_gate_edge.sv
module pic_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/pic_next_count.sv
module pic_next_count
  import pic_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] init_i,
  input  logic [2:0]    em_i,
  input  logic          out_i,
  output logic [CW-1:0] nxt_o,
  output logic          at_one_o,
  output logic          at_two_o
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  // start value of a square-wave half: odd values split unevenly
  function automatic logic [CW-1:0] half_start(input logic [CW-1:0] v, input logic hi);
    if (!v[0]) return v;
    return hi ? v + ONE : v - ONE;
  endfunction

  assign at_one_o = (cnt_i == ONE);
  assign at_two_o = (cnt_i == TWO);

  always_comb begin
    unique case (em_i)
      MODE_SQUARE: nxt_o = at_two_o ? half_start(init_i, ~out_i) : cnt_i - TWO;
      MODE_RATE:   nxt_o = at_one_o ? init_i : cnt_i - ONE;
      default:     nxt_o = cnt_i - ONE;
    endcase
  end
endmodule

// File: rtl/pic_out_wave.sv
module pic_out_wave
  import pic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_fire_i,
  input  logic [2:0] ld_em_i,
  input  logic       restart_i,
  input  logic       tick_i,
  input  logic [2:0] em_i,
  input  logic       at_one_i,
  input  logic       at_two_i,
  output logic       out_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_o <= 1'b0;
    end else if (ld_fire_i) begin
      out_o <= (ld_em_i != MODE_TERM);
    end else if (restart_i) begin
      out_o <= 1'b1;
    end else if (tick_i) begin
      unique case (em_i)
        MODE_TERM:   if (at_one_i) out_o <= 1'b1;
        MODE_RATE:   begin
          if (at_two_i)      out_o <= 1'b0;
          else if (at_one_i) out_o <= 1'b1;
        end
        MODE_SQUARE: if (at_two_i) out_o <= ~out_o;
        default:     out_o <= out_o;
      endcase
    end
  end
endmodule

// File: rtl/pic_channel.sv
module pic_channel
  import pic_pkg::*;
#(
  parameter int CW = 16,
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          gate,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [CW-1:0] ld_value,
  input  logic [MW-1:0] ld_mode,
  input  logic          ld_bcd,
  output logic [CW-1:0] count_o,
  output logic          out_o,
  output logic [MW-1:0] mode_o,
  output logic          bcd_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [MW-1:0] mode_q;
  logic          bcd_q;
  logic [CW-1:0] init_q, cnt_q, cnt_nxt;
  logic          armed_q;
  logic [2:0]    em, ld_em;
  logic          ld_fire, rise, restart, tick_act, at_one, at_two;

  // first count after a load or restart; square wave starts even
  function automatic logic [CW-1:0] first_val(input logic [CW-1:0] v, input logic [2:0] m);
    return (m == MODE_SQUARE && v[0]) ? v + ONE : v;
  endfunction

  assign ld_ready = 1'b1;
  assign ld_fire  = ld_valid & ld_ready;
  assign em       = eff_mode(mode_q);
  assign ld_em    = eff_mode(ld_mode);
  assign restart  = armed_q & rise & gate_retrigs(em) & ~ld_fire;
  assign tick_act = tick_en & armed_q & (gate | ~gate_pauses(em)) & ~ld_fire & ~restart;

  pic_gate_edge u_gate (
    .clk(clk), .rst_n(rst_n), .gate_i(gate), .rise_o(rise)
  );

  pic_next_count #(.CW(CW)) u_next (
    .cnt_i(cnt_q), .init_i(init_q), .em_i(em), .out_i(out_o),
    .nxt_o(cnt_nxt), .at_one_o(at_one), .at_two_o(at_two)
  );

  pic_out_wave u_out (
    .clk(clk), .rst_n(rst_n), .ld_fire_i(ld_fire), .ld_em_i(ld_em),
    .restart_i(restart), .tick_i(tick_act), .em_i(em),
    .at_one_i(at_one), .at_two_i(at_two), .out_o(out_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      bcd_q   <= 1'b0;
      init_q  <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (ld_fire) begin
      mode_q  <= ld_mode;
      bcd_q   <= ld_bcd;
      init_q  <= ld_value;
      cnt_q   <= first_val(ld_value, ld_em);
      armed_q <= 1'b1;
    end else if (restart) begin
      cnt_q <= first_val(init_q, em);
    end else if (tick_act) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign count_o = cnt_q;
  assign mode_o  = mode_q;
  assign bcd_o   = bcd_q;

  assert_idle_before_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (cnt_q == '0 && !out_o));

  assert_term_rise_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (em == MODE_TERM && $rose(out_o)) |-> (cnt_q == '0));

  assert_gate_pause_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && gate_pauses(em) && !gate && !ld_fire) |=> (cnt_q == $past(cnt_q)));

  assert_retrig_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && rise && !ld_fire && (em == MODE_ONESHOT || em == MODE_RATE || em == MODE_HWSTB))
      |=> (cnt_q == $past(init_q) && out_o));

  assert_rate_low_only_at_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && em == MODE_RATE && !out_o) |-> (cnt_q == ONE));

  assert_square_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && em == MODE_SQUARE) |-> !cnt_q[0]);

  assert_no_tick_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ld_fire && !restart) |=> (cnt_q == $past(cnt_q) && out_o == $past(out_o)));
endmodule

// File: tb/tb_pic_channel.sv
`timescale 1ns/1ps
module tb_pic_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        gate = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [15:0] ld_value = '0;
  logic [2:0]  ld_mode = '0;
  logic        ld_bcd = 1'b0;
  logic [15:0] count_o;
  logic        out_o;
  logic [2:0]  mode_o;
  logic        bcd_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pic_channel dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_value(ld_value),
    .ld_mode(ld_mode), .ld_bcd(ld_bcd), .count_o(count_o), .out_o(out_o),
    .mode_o(mode_o), .bcd_o(bcd_o)
  );

  // reference model state
  logic [15:0] m_cnt = '0, m_init = '0;
  logic [2:0]  m_mode = '0;
  logic        m_out = 1'b0, m_armed = 1'b0, m_gprev = 1'b0;
  string       m_tag = "R1";

  function automatic logic [2:0] effm(input logic [2:0] m);
    return m[1] ? {1'b0, m[1:0]} : m;
  endfunction

  function automatic logic [15:0] start_of(input logic [15:0] v, input logic [2:0] em, input logic hi);
    if (em != 3'd3 || !v[0]) return v;
    return hi ? v + 16'd1 : v - 16'd1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic       rise = gate & ~m_gprev;
    logic [2:0] em = effm(m_mode);
    m_gprev = gate;
    if (ld_valid) begin
      m_tag = "R2";
      m_mode = ld_mode; m_init = ld_value; m_armed = 1'b1;
      m_cnt = start_of(ld_value, effm(ld_mode), 1'b1);
      m_out = (effm(ld_mode) != 3'd0);
    end else if (!m_armed) begin
      m_tag = "R1";
    end else if (rise && (em == 1 || em == 2 || em == 3 || em == 5)) begin
      m_tag = "R6";
      m_cnt = start_of(m_init, em, 1'b1);
      m_out = 1'b1;
    end else if (!tick_en) begin
      m_tag = "R10";
    end else if ((em == 0 || em == 4) && !gate) begin
      m_tag = "R5";
    end else begin
      case (em)
        3'd3: begin
          m_tag = "R8";
          if (m_cnt == 16'd2) begin
            m_out = ~m_out;
            m_cnt = start_of(m_init, em, m_out);
          end else m_cnt = m_cnt - 16'd2;
        end
        3'd2: begin
          m_tag = "R7";
          if (m_cnt == 16'd1) begin m_cnt = m_init; m_out = 1'b1; end
          else begin m_cnt = m_cnt - 16'd1; if (m_cnt == 16'd1) m_out = 1'b0; end
        end
        3'd0: begin
          m_tag = "R4";
          m_cnt = m_cnt - 16'd1;
          if (m_cnt == 16'd0) m_out = 1'b1;
        end
        default: begin m_tag = "R4"; m_cnt = m_cnt - 16'd1; end
      endcase
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    #1;
    chk(m_tag, 32'(count_o), 32'(m_cnt));
    chk(m_tag, 32'(out_o), 32'(m_out));
  endtask

  task automatic load(input logic [2:0] m, input logic [15:0] v, input logic b);
    ld_valid = 1'b1; ld_mode = m; ld_value = v; ld_bcd = b;
    step();
    ld_valid = 1'b0;
  endtask

  task automatic run_until_change(output int n);
    logic s = out_o;
    n = 0;
    do begin step(); n++; end while (out_o == s && n < 70000);
  endtask

  int n;

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    chk("R1 count", 32'(count_o), 0);
    chk("R1 out", 32'(out_o), 0);
    chk("R1 mode", 32'(mode_o), 0);
    chk("R1 ready", 32'(ld_ready), 1);
    tick_en = 1'b1; gate = 1'b1;
    repeat (5) step();
    chk("R1 hold", 32'(count_o), 0);

    // R2: load stores value, mode, flag
    load(3'd4, 16'h1234, 1'b1);
    chk("R2 count", 32'(count_o), 32'h1234);
    chk("R2 mode", 32'(mode_o), 4);
    chk("R2 bcd", 32'(bcd_o), 1);
    repeat (3) step();
    chk("R4 decrement", 32'(count_o), 32'h1231);

    // R4: wrap past zero
    load(3'd1, 16'd2, 1'b0);
    repeat (3) step();
    chk("R4 wrap", 32'(count_o), 32'hFFFF);
    chk("R4 out mode1", 32'(out_o), 1);

    // R10: tick enable low freezes
    tick_en = 1'b0;
    repeat (5) step();
    chk("R10 hold", 32'(count_o), 32'hFFFF);
    tick_en = 1'b1;

    // R5: gate pauses mode 0, edge does not reload
    gate = 1'b0;
    load(3'd0, 16'd5, 1'b0);
    repeat (4) step();
    chk("R5 paused", 32'(count_o), 5);
    tick_en = 1'b0; step(); step();
    load(3'd0, 16'd5, 1'b0);
    tick_en = 1'b1;
    step();                          // paused tick
    gate = 1'b1; step();             // rising edge: counts 5->4, no reload
    chk("R5 no reload", 32'(count_o), 4);
    repeat (3) step();
    chk("R4 out low before zero", 32'(out_o), 0);
    step();
    chk("R4 out high at zero", 32'(out_o), 1);
    chk("R4 count zero", 32'(count_o), 0);

    // R3: zero means 65536 ticks
    load(3'd0, 16'd0, 1'b0);
    run_until_change(n);
    chk("R3 full period", 32'(n), 65536);

    // R7: rate generator N=4
    load(3'd2, 16'd4, 1'b0);
    run_until_change(n);
    chk("R7 first low", 32'(n), 3);
    chk("R7 low count", 32'(count_o), 1);
    run_until_change(n);
    chk("R7 low width", 32'(n), 1);
    chk("R7 reload", 32'(count_o), 4);
    run_until_change(n);
    chk("R7 high width", 32'(n), 3);

    // R8: square wave odd and even
    load(3'd3, 16'd5, 1'b0);
    chk("R8 odd start", 32'(count_o), 6);
    run_until_change(n);
    chk("R8 odd high", 32'(n), 3);
    chk("R8 low start", 32'(count_o), 4);
    run_until_change(n);
    chk("R8 odd low", 32'(n), 2);
    load(3'd3, 16'd6, 1'b0);
    run_until_change(n);
    chk("R8 even high", 32'(n), 3);
    run_until_change(n);
    chk("R8 even low", 32'(n), 3);

    // R6: retrigger in mode 2
    load(3'd2, 16'd10, 1'b0);
    repeat (3) step();
    gate = 1'b0; step();
    gate = 1'b1; step();
    chk("R6 restart", 32'(count_o), 10);
    chk("R6 out high", 32'(out_o), 1);

    // R9: mode 7 aliases square wave
    load(3'd7, 16'd6, 1'b0);
    chk("R9 mode_o", 32'(mode_o), 7);
    run_until_change(n);
    chk("R9 square half", 32'(n), 3);
    load(3'd6, 16'd3, 1'b0);
    run_until_change(n);
    chk("R9 rate first low", 32'(n), 2);

    // random mix, checked against the model every cycle
    for (int i = 0; i < 6000; i++) begin
      ld_valid = ($urandom % 40 == 0);
      ld_mode  = 3'($urandom % 8);
      ld_value = 16'($urandom % 24);
      if ($urandom % 4 == 0) ld_value = 16'($urandom);
      if ((effm(ld_mode) == 3'd2 || effm(ld_mode) == 3'd3) && ld_value == 16'd1) ld_value = 16'd2;
      ld_bcd   = 1'($urandom);
      if ($urandom % 8 == 0) gate = ~gate;
      tick_en  = ($urandom % 10 < 7);
      step();
      if (ld_valid) chk("R2 random mode", 32'(mode_o), 32'(ld_mode));
      ld_valid = 1'b0;
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule